// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block turns a register-programmed divisor into the two timing pulses a UART needs. One is a 16x oversample tick that the receiver uses to sample the line. The other is a bit strobe that marks the end of each bit period for the transmitter and the receiver. The divisor has an integer part `div` and a 4-bit fractional extension `ext`. One bit period lasts 16*(div+1)+ext input clocks, so the rate can be set more finely than a plain divide by sixteen allows.

Software works out the register values itself. It rounds clock/baud to the nearest integer. The low nibble of that integer becomes `ext`, and the remaining upper bits, minus one, become `div`. The fastest rate is one sixteenth of the input clock, reached with `div` = 0 and `ext` = 0.

Each bit period is split into 16 oversample slots. The `ext` extra clocks are handed out one each to the first `ext` slots, so ticks stay evenly spaced to within one clock. The divisor is captured into a shadow copy while the block is disabled and at every bit-period boundary. A divisor written mid-period therefore never bends the period in progress. Dropping the enable holds all counters at their reset value, and raising it again starts a fresh bit period.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, and on every clock while `en_i` is low, both `os_tick_o` and `bit_strobe_o` are low.
- R2: The divisor is read as div = {`div_hi_i`, `div_lo_i[7:0]`} and ext = `div_lo_i[15:12]`. Oversample slot s (numbered 0 to 15 within a bit period) lasts div+2 clocks when s < ext and div+1 clocks otherwise, and `os_tick_o` is high for exactly one clock, the last clock of each slot.
- R3: A bit period lasts 16*(div+1)+ext clocks, measured from its first enabled clock to its last.
- R4: `bit_strobe_o` is high for exactly one clock per bit period. That clock is the one carrying the 16th `os_tick_o` of the period, and the strobe is never high without a tick.
- R5: With div = 0 and ext = 0, `os_tick_o` is high on every enabled clock and `bit_strobe_o` is high on every 16th.
- R6: Divisor inputs present on the clock that carries `bit_strobe_o` govern the following bit period. Changes made at any other enabled clock do not alter the period in progress.
- R7: Lowering `en_i` part-way through a period discards the partial period. On re-enabling, the first tick comes after div+1+(ext>0 ? 1 : 0) clocks, counting the first enabled clock as clock 1, using the divisor present on the last disabled clock.
- R8: Bits [11:8] of `div_lo_i` have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock that the divisor counts |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low holds the counters cleared |
| div_lo_i | input | 16 | Low divisor word: div low byte in [7:0], ext in [15:12] |
| div_hi_i | input | DIV_W-8 (8) | Divisor bits above bit 7 |
| os_tick_o | output | 1 | One-clock oversample tick at the end of each slot |
| bit_strobe_o | output | 1 | One-clock strobe at the end of each bit period |

## Verification
Two events can land in the same clock: the final tick of a period, which also raises the bit strobe, and the capture of a new divisor. The stimulus rewrites the divisor on clocks scattered through a period, including the very clock that carries the strobe. It then checks every clock of the following period against tick positions worked out from the new values, while the period in progress must keep the old values. A second pairing arises when the enable is dropped on a clock that would have ended a slot. Here the bench requires silence on that clock and a full-length first slot after re-enable.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  // Width of the low divisor register word and where its fields sit.
  localparam int unsigned LO_WORD_W = 16;
  localparam int unsigned LO_BYTE_W = 8;

  // A slot earns one extra clock when its index is below the extension value.
  function automatic logic slot_is_long(input logic [7:0] slot_idx,
                                        input logic [7:0] ext_val);
    return slot_idx < ext_val;
  endfunction
endpackage

// File: rtl/frac_baud_shadow.sv
module frac_baud_shadow #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned EXT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [EXT_W-1:0] ext_i,
  output logic [DIV_W-1:0] div_q_o,
  output logic [EXT_W-1:0] ext_q_o
);
  logic [DIV_W-1:0] div_d, div_q;
  logic [EXT_W-1:0] ext_d, ext_q;

  always_comb begin
    div_d = div_q;
    ext_d = ext_q;
    if (load_i) begin
      div_d = div_i;
      ext_d = ext_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ext_q <= '0;
    end else begin
      div_q <= div_d;
      ext_q <= ext_d;
    end
  end

  assign div_q_o = div_q;
  assign ext_q_o = ext_q;
endmodule

// File: rtl/frac_baud_slot_timer.sv
module frac_baud_slot_timer #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] len_m1_i,
  output logic             slot_end_o
);
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == len_m1_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i) begin
      cnt_d = '0;
    end else if (at_end) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign slot_end_o = en_i && at_end;
endmodule

// File: rtl/frac_baud_slot_index.sv
module frac_baud_slot_index #(
  parameter int unsigned SLOTS = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     step_i,
  output logic [$clog2(SLOTS)-1:0] idx_o,
  output logic                     last_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] idx_d, idx_q;

  always_comb begin
    idx_d = idx_q;
    if (!en_i) begin
      idx_d = '0;
    end else if (step_i) begin
      idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_d;
    end
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == LAST_IDX);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned SLOTS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [15:0]         div_lo_i,
  input  logic [DIV_W-9:0]    div_hi_i,
  output logic                os_tick_o,
  output logic                bit_strobe_o
);
  import frac_baud_pkg::*;

  localparam int unsigned EXT_W  = $clog2(SLOTS);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned CNT_W  = DIV_W + 1;
  localparam int unsigned EXT_LO = LO_WORD_W - EXT_W;

  logic [DIV_W-1:0]  div_in, div_q;
  logic [EXT_W-1:0]  ext_in, ext_q;
  logic [SLOT_W-1:0] slot_idx;
  logic              slot_last;
  logic              slot_end;
  logic              long_slot;
  logic              period_end;
  logic              shadow_load;
  logic [CNT_W-1:0]  len_m1;

  // Field extraction: bits between the low byte and the extension are unused.
  assign div_in = {div_hi_i, div_lo_i[LO_BYTE_W-1:0]};
  assign ext_in = div_lo_i[LO_WORD_W-1:EXT_LO];

  // Capture while idle and at each period boundary only.
  assign shadow_load = !en_i || period_end;

  frac_baud_shadow #(
    .DIV_W(DIV_W),
    .EXT_W(EXT_W)
  ) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (shadow_load),
    .div_i  (div_in),
    .ext_i  (ext_in),
    .div_q_o(div_q),
    .ext_q_o(ext_q)
  );

  assign long_slot = slot_is_long(8'(slot_idx), 8'(ext_q));
  assign len_m1    = {1'b0, div_q} + CNT_W'(long_slot);

  frac_baud_slot_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .len_m1_i  (len_m1),
    .slot_end_o(slot_end)
  );

  frac_baud_slot_index #(
    .SLOTS(SLOTS)
  ) u_index (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .step_i(slot_end),
    .idx_o (slot_idx),
    .last_o(slot_last)
  );

  assign period_end   = slot_end && slot_last;
  assign os_tick_o    = slot_end;
  assign bit_strobe_o = period_end;
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned SLOTS = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     en_i,
  input logic                     os_tick_o,
  input logic                     bit_strobe_o,
  input logic [DIV_W-1:0]         div_q,
  input logic [$clog2(SLOTS)-1:0] ext_q
);
  localparam int unsigned GW     = DIV_W + 2;
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST_TICK = SLOT_W'(SLOTS - 1);

  logic [GW-1:0]     gap_q;
  logic [SLOT_W-1:0] tcnt_q;
  logic [GW-1:0]     seen_len, short_len, long_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      tcnt_q <= '0;
    end else if (!en_i) begin
      gap_q  <= '0;
      tcnt_q <= '0;
    end else if (os_tick_o) begin
      gap_q  <= '0;
      tcnt_q <= tcnt_q + SLOT_W'(1);
    end else begin
      gap_q  <= gap_q + GW'(1);
    end
  end

  assign seen_len  = gap_q + GW'(1);
  assign short_len = GW'(div_q) + GW'(1);
  assign long_len  = GW'(div_q) + GW'(2);

  assert_quiet_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!os_tick_o && !bit_strobe_o));

  assert_slot_length_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    os_tick_o |-> (seen_len == ((tcnt_q < ext_q) ? long_len : short_len)));

  assert_strobe_on_last_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (os_tick_o && tcnt_q == LAST_TICK) |-> bit_strobe_o);

  assert_strobe_needs_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_strobe_o |-> (os_tick_o && tcnt_q == LAST_TICK));

  assert_divisor_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bit_strobe_o) |=> ($stable(div_q) && $stable(ext_q)));
endmodule

bind frac_baud_gen frac_baud_gen_chk #(
  .DIV_W(DIV_W),
  .SLOTS(SLOTS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .os_tick_o   (os_tick_o),
  .bit_strobe_o(bit_strobe_o),
  .div_q       (div_q),
  .ext_q       (ext_q)
);

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
  localparam time TCLK = 20ns;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [15:0] div_lo;
  logic [7:0]  div_hi;
  logic        tick;
  logic        strobe;

  int checks;
  int errors;
  bit done;

  frac_baud_gen u_frac_baud_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .div_lo_i    (div_lo),
    .div_hi_i    (div_hi),
    .os_tick_o   (tick),
    .bit_strobe_o(strobe)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  // Tick positions inside a period follow R2: slot s lasts d+1 (+1 if s<e).
  function automatic bit tick_due(int p, int d, int e);
    for (int s = 0; s < 16; s++) begin
      int k;
      k = s + 1;
      if (p == k * (d + 1) + ((k < e) ? k : e)) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic int period_len(int d, int e);
    return 16 * (d + 1) + e;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_div(int d, int e, int junk);
    div_lo = {4'(e), 4'(junk), 8'(d)};
    div_hi = 8'(d >> 8);
  endtask

  // Disabled idle, then run ncyc enabled clocks; at clock chg, new divisor.
  task automatic run_case(string req, int d, int e, int junk, int ncyc,
                          int chg, int nd, int ne);
    int cur_d, cur_e, p;
    bit bad_tick, bad_strobe;
    int first_bad;
    @(negedge clk);
    en = 1'b0;
    set_div(d, e, junk);
    repeat (2) begin
      @(negedge clk);
      #2;
      check(!tick && !strobe, "R1", "output while disabled", {tick, strobe}, 0);
    end
    cur_d = d;
    cur_e = e;
    p = 1;
    bad_tick = 1'b0;
    bad_strobe = 1'b0;
    first_bad = -1;
    for (int c = 1; c <= ncyc; c++) begin
      bit et, es;
      @(negedge clk);
      en = 1'b1;
      if (c == chg) set_div(nd, ne, junk ^ 5);
      #2;
      et = tick_due(p, cur_d, cur_e);
      es = (p == period_len(cur_d, cur_e));
      if (tick !== et && !bad_tick) begin
        bad_tick = 1'b1;
        check(1'b0, req, "tick (R2) at clock", c, et);
      end
      if (strobe !== es && !bad_strobe) begin
        bad_strobe = 1'b1;
        check(1'b0, req, "strobe (R3/R4 timing) at clock", c, es);
      end
      if (es) begin
        cur_d = int'({div_hi, div_lo[7:0]});
        cur_e = int'(div_lo[15:12]);
        p = 1;
      end else begin
        p++;
      end
    end
    check(!bad_tick, req, "tick pattern over run, R2", bad_tick, 0);
    check(!bad_strobe, req, "strobe pattern over run, R3 R4", bad_strobe, 0);
  endtask

  initial begin
    #(TCLK * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    en = 1'b0;
    div_lo = 16'h0000;
    div_hi = 8'h00;
    repeat (3) @(negedge clk);
    #2;
    check(!tick && !strobe, "R1", "output in reset", {tick, strobe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    check(!tick && !strobe, "R1", "output after reset", {tick, strobe}, 0);

    // R5: fastest rate, tick every clock, strobe every 16th.
    run_case("R5", 0, 0, 0, 64, 0, 0, 0);
    // Largest extension and a mid-size one.
    run_case("R2", 0, 15, 0, 93, 0, 0, 0);
    run_case("R3", 3, 7, 0, 3 * period_len(3, 7), 0, 0, 0);
    // High byte in use: div = 0x0102.
    run_case("R2", 258, 9, 0, period_len(258, 9) + 20, 0, 0, 0);
    // R8: junk in bits [11:8] must not matter.
    run_case("R8", 5, 3, 15, 2 * period_len(5, 3), 0, 0, 0);
    // R6: change mid-period, and change exactly on the strobe clock.
    run_case("R6", 2, 4, 0, 3 * period_len(2, 4), 20, 6, 11);
    run_case("R6", 1, 2, 0, 3 * period_len(1, 2) + 40, period_len(1, 2), 4, 13);
    // R7: stop part-way through a period, then start over with another divisor.
    run_case("R7", 4, 5, 0, 37, 0, 0, 0);
    run_case("R7", 6, 1, 0, period_len(6, 1) + 10, 0, 0, 0);

    for (int i = 0; i < 24; i++) begin
      int d, e, j, nd, ne, n;
      d  = int'($urandom % 24);
      e  = int'($urandom % 16);
      j  = int'($urandom % 16);
      nd = int'($urandom % 24);
      ne = int'($urandom % 16);
      n  = period_len(d, e) + int'($urandom % 300) + 1;
      run_case("R6", d, e, j, n, int'($urandom % 400) + 1, nd, ne);
    end

    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    #2;
    check(!tick && !strobe, "R1", "output after final disable", {tick, strobe}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule